// File: doc/BRIEF.md
# Tri-Level Control Pulse Qualifier

This block turns a single three-level control pin into clean adjustment commands. The pin is observed through three digitized comparator flags: one for "below the low threshold", one for "above the high threshold" and one for "above the programming threshold". When no flag is set, the pin sits at its mid (rest) level. A floating or undriven pin rests at mid level, so it produces no commands.

Each time the pin leaves mid level and comes back is one excursion. The block measures how long each excursion lasts by counting a clock-enable tick of fixed period. A low excursion that is long enough becomes a one-cycle increment strobe. A high excursion that is long enough becomes a one-cycle decrement strobe. The strobe is issued when the pin returns to mid, not when it leaves. Short glitches are discarded. An excursion that starts too soon after the previous one is also discarded.

Holding the pin at the programming level for long enough raises a single program-request strobe. The excursion that carries it never also counts as a decrement. All widths are parameters counted in ticks. The comparators, the pin bias network and the counter that consumes the strobes sit outside the block.

Top module: `tri_pulse_qualifier`

## Requirements
- R1: A synchronous active-high reset holds all three strobes low, abandons any excursion in progress and returns the block to mid/idle. After reset the required mid-level gap counts as already met.
- R2: A low excursion (only the low flag set) lasting at least VALID_TICKS ticks produces exactly one incStrobe. The strobe is high in the second clock cycle after the flags return to mid.
- R3: A high excursion (the high flag set, the programming flag clear) lasting at least VALID_TICKS ticks produces exactly one decStrobe, with the same timing as R2.
- R4: An excursion that lasts fewer than VALID_TICKS ticks produces no strobe. This covers both glitches below the rejection width and pulses between the rejection width and the valid width.
- R5: An excursion that begins after fewer than GAP_TICKS ticks of mid level since the previous excursion ended produces no strobe.
- R6: Holding the programming flag continuously for PROG_TICKS ticks produces exactly one progStrobe per hold. The strobe is high two clock cycles after the programming flag is sampled for the tick that completes the count. A longer hold adds no further strobes.
- R7: An excursion that touches the programming level at any point produces neither incStrobe nor decStrobe.
- R8: An excursion that switches directly between low and high without passing through mid produces no strobe.
- R9: With all three flags clear, no strobe is ever issued.
- R10: Each strobe lasts exactly one clock cycle, and at most one of the three strobes is high in any cycle.
- R11: Flags are decoded with priority programming over high over low. Low and high flags set together therefore count as a high excursion.
- R12: An excursion much longer than VALID_TICKS still yields exactly one strobe. The width count saturates rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle time-base tick used for all width counts |
| lowFlag | input | 1 | Pin is below the low threshold |
| highFlag | input | 1 | Pin is above the high threshold |
| progFlag | input | 1 | Pin is above the programming threshold |
| incStrobe | output | 1 | One-cycle increment command |
| decStrobe | output | 1 | One-cycle decrement command |
| progStrobe | output | 1 | One-cycle program request |

## Verification
The bench targets the boundaries where a qualifier typically goes wrong, each with its own failure mode:

- **Command on the leading edge.** Firing on the departure from mid instead of the return would show up in the exact-cycle strobe check.
- **No minimum width.** Counting short pulses would give spurious increments and decrements.
- **Gap ignored.** A back-to-back pair of excursions would count twice.
- **Program hold taken for a decrement.** The long programming hold would also adjust the counter on release.
- **Program request retriggered.** A repeating request would pulse several times during one long hold.
- **Wrapping width counter.** A very long press would wrap back below the threshold and be dropped.
- **Direct swing and reset.** A direct low-to-high swing and a reset in the middle of an excursion must both leave the count untouched.
- **Tied flags.** Simultaneous low and high flags must resolve to a decrement.

// File: rtl/tpq_pkg.sv
package tpq_pkg;

  // Decoded pin level after flag priority (programming > high > low)
  typedef enum logic [1:0] {
    LVL_MID  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_PROG = 2'd3
  } level_e;

  // Control -> datapath: one-cycle fire requests
  typedef struct packed {
    logic fireInc;
    logic fireDec;
    logic fireProg;
  } fire_t;

  // Datapath -> control: measured conditions
  typedef struct packed {
    level_e level;
    logic   widthOk;
    logic   gapOk;
    logic   progHit;
  } status_t;

endpackage

// File: rtl/tpq_sat_counter.sv
module tpq_sat_counter #(
  parameter int LIMIT      = 10,
  parameter bit RESET_FULL = 1'b0,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         full,
  output logic         willFill
);

  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RESET_FULL ? LIM : '0;
    end else if (clr) begin
      count <= '0;
    end else if (step && (count != LIM)) begin
      count <= count + 1'b1;
    end
  end

  assign full     = (count == LIM);
  assign willFill = step && !clr && (count == LIM - 1'b1);

endmodule

// File: rtl/tpq_datapath.sv
module tpq_datapath
  import tpq_pkg::*;
#(
  parameter int VALID_TICKS = 50,
  parameter int GAP_TICKS   = 3,
  parameter int PROG_TICKS  = 50
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tickEn,
  input  logic    lowFlag,
  input  logic    highFlag,
  input  logic    progFlag,
  input  fire_t   fire,
  output status_t status,
  output logic    incStrobe,
  output logic    decStrobe,
  output logic    progStrobe
);

  localparam int WW = $clog2(VALID_TICKS + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam int PW = $clog2(PROG_TICKS + 1);

  level_e levelQ;
  level_e levelD;

  logic [WW-1:0] widthCount;
  logic [GW-1:0] gapCount;
  logic [PW-1:0] progCount;
  logic widthFull, widthFillUnused;
  logic gapFull, gapFillUnused;
  logic progFull, progFill;

  // Priority decode of the comparator flags
  always_comb begin
    if (progFlag)      levelD = LVL_PROG;
    else if (highFlag) levelD = LVL_HIGH;
    else if (lowFlag)  levelD = LVL_LOW;
    else               levelD = LVL_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) levelQ <= LVL_MID;
    else     levelQ <= levelD;
  end

  // Ticks spent away from mid during the current excursion
  tpq_sat_counter #(.LIMIT(VALID_TICKS), .RESET_FULL(1'b0)) widthCtr (
    .clk(clk), .rst(rst),
    .clr(levelQ == LVL_MID), .step(tickEn),
    .count(widthCount), .full(widthFull), .willFill(widthFillUnused)
  );

  // Ticks spent at mid since the last excursion ended
  tpq_sat_counter #(.LIMIT(GAP_TICKS), .RESET_FULL(1'b1)) gapCtr (
    .clk(clk), .rst(rst),
    .clr(levelQ != LVL_MID), .step(tickEn),
    .count(gapCount), .full(gapFull), .willFill(gapFillUnused)
  );

  // Ticks of continuous programming level
  tpq_sat_counter #(.LIMIT(PROG_TICKS), .RESET_FULL(1'b0)) progCtr (
    .clk(clk), .rst(rst),
    .clr(levelQ != LVL_PROG), .step(tickEn),
    .count(progCount), .full(progFull), .willFill(progFill)
  );

  always_comb begin
    status.level   = levelQ;
    status.widthOk = widthFull;
    status.gapOk   = gapFull;
    status.progHit = progFill && (levelQ == LVL_PROG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      incStrobe  <= 1'b0;
      decStrobe  <= 1'b0;
      progStrobe <= 1'b0;
    end else begin
      incStrobe  <= fire.fireInc;
      decStrobe  <= fire.fireDec;
      progStrobe <= fire.fireProg;
    end
  end

endmodule

// File: rtl/tpq_control.sv
module tpq_control
  import tpq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  status_t status,
  output fire_t   fire
);

  typedef enum logic [1:0] {
    S_MID  = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2,
    S_VOID = 2'd3
  } state_e;

  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    fire   = '0;
    fire.fireProg = status.progHit;
    unique case (stateQ)
      S_MID: begin
        unique case (status.level)
          LVL_LOW:  stateD = status.gapOk ? S_LOW  : S_VOID;
          LVL_HIGH: stateD = status.gapOk ? S_HIGH : S_VOID;
          LVL_PROG: stateD = S_VOID;
          default:  stateD = S_MID;
        endcase
      end
      S_LOW: begin
        unique case (status.level)
          LVL_MID: begin
            fire.fireInc = status.widthOk;
            stateD = S_MID;
          end
          LVL_LOW: stateD = S_LOW;
          default: stateD = S_VOID;
        endcase
      end
      S_HIGH: begin
        unique case (status.level)
          LVL_MID: begin
            fire.fireDec = status.widthOk;
            stateD = S_MID;
          end
          LVL_HIGH: stateD = S_HIGH;
          default:  stateD = S_VOID;
        endcase
      end
      default: begin
        if (status.level == LVL_MID) stateD = S_MID;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_MID;
    else     stateQ <= stateD;
  end

endmodule

// File: rtl/tri_pulse_qualifier.sv
module tri_pulse_qualifier
  import tpq_pkg::*;
#(
  parameter int VALID_TICKS = 50,
  parameter int GAP_TICKS   = 3,
  parameter int PROG_TICKS  = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tickEn,
  input  logic lowFlag,
  input  logic highFlag,
  input  logic progFlag,
  output logic incStrobe,
  output logic decStrobe,
  output logic progStrobe
);

  fire_t   fire;
  status_t status;

  tpq_datapath #(
    .VALID_TICKS(VALID_TICKS),
    .GAP_TICKS(GAP_TICKS),
    .PROG_TICKS(PROG_TICKS)
  ) dpath (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .lowFlag(lowFlag), .highFlag(highFlag), .progFlag(progFlag),
    .fire(fire), .status(status),
    .incStrobe(incStrobe), .decStrobe(decStrobe), .progStrobe(progStrobe)
  );

  tpq_control ctrl (
    .clk(clk), .rst(rst), .status(status), .fire(fire)
  );

endmodule

// File: rtl/tpq_checker.sv
module tpq_checker (
  input logic clk,
  input logic rst,
  input logic lowFlag,
  input logic highFlag,
  input logic progFlag,
  input logic incStrobe,
  input logic decStrobe,
  input logic progStrobe
);

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1: one edge after a reset edge every strobe is low
  always_ff @(posedge clk) begin
    if (rstSeen == 1'b1) begin
      a_r1_reset_quiet: assert (!incStrobe && !decStrobe && !progStrobe)
        else $error("R1 strobe high after reset");
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({incStrobe, decStrobe, progStrobe}));

  a_r10_inc_single: assert property (@(posedge clk) disable iff (rst)
    incStrobe |=> !incStrobe);

  a_r10_dec_single: assert property (@(posedge clk) disable iff (rst)
    decStrobe |=> !decStrobe);

  a_r6_prog_single: assert property (@(posedge clk) disable iff (rst)
    progStrobe |=> !progStrobe);

  a_r2_inc_from_low: assert property (@(posedge clk) disable iff (rst)
    incStrobe |-> $past(lowFlag && !highFlag && !progFlag, 3));

  a_r3_dec_from_high: assert property (@(posedge clk) disable iff (rst)
    decStrobe |-> $past(highFlag && !progFlag, 3));

  a_r6_prog_from_level: assert property (@(posedge clk) disable iff (rst)
    progStrobe |-> $past(progFlag, 2));

endmodule

bind tri_pulse_qualifier tpq_checker chk (
  .clk(clk), .rst(rst),
  .lowFlag(lowFlag), .highFlag(highFlag), .progFlag(progFlag),
  .incStrobe(incStrobe), .decStrobe(decStrobe), .progStrobe(progStrobe)
);

// File: tb/tb_tri_pulse_qualifier.sv
`timescale 1ns/1ps
module tb_tri_pulse_qualifier;

  localparam int VALID    = 10;
  localparam int GAP      = 3;
  localparam int PROGT    = 10;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst;
  logic tickEn;
  logic lowFlag, highFlag, progFlag;
  logic incStrobe, decStrobe, progStrobe;

  int nInc = 0, nDec = 0, nProg = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_pulse_qualifier #(.VALID_TICKS(VALID), .GAP_TICKS(GAP), .PROG_TICKS(PROGT)) dut (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .lowFlag(lowFlag), .highFlag(highFlag), .progFlag(progFlag),
    .incStrobe(incStrobe), .decStrobe(decStrobe), .progStrobe(progStrobe)
  );

  // time-base tick, one clock in TICK_DIV
  initial begin
    int phase = 0;
    tickEn = 1'b0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % TICK_DIV;
      tickEn = (phase == 0);
    end
  end

  always @(negedge clk) begin
    if (incStrobe)  nInc++;
    if (decStrobe)  nDec++;
    if (progStrobe) nProg++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setFlags(input bit lo, input bit hi, input bit pr);
    @(negedge clk);
    lowFlag = lo; highFlag = hi; progFlag = pr;
  endtask

  task automatic holdFor(input int ticks);
    repeat (ticks * TICK_DIV) @(negedge clk);
  endtask

  task automatic excursion(input bit lo, input bit hi, input bit pr, input int ticks);
    setFlags(lo, hi, pr);
    holdFor(ticks);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(GAP + 3);
  endtask

  task automatic expectCounts(input string tag, input int i0, input int d0, input int p0,
                              input int di, input int dd, input int dp);
    check((nInc - i0) == di, {tag, " inc"}, nInc - i0, di);
    check((nDec - d0) == dd, {tag, " dec"}, nDec - d0, dd);
    check((nProg - p0) == dp, {tag, " prog"}, nProg - p0, dp);
  endtask

  task automatic testReset();
    rst = 1'b1;
    lowFlag = 1'b0; highFlag = 1'b0; progFlag = 1'b0;
    repeat (4) @(negedge clk);
    check(!incStrobe && !decStrobe && !progStrobe, "R1 strobes low in reset",
          {incStrobe, decStrobe, progStrobe}, 0);
    rst = 1'b0;
  endtask

  task automatic testIncLatency();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b1, 1'b0, 1'b0);
    holdFor(20);
    setFlags(1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(posedge clk);
    #1;
    check(incStrobe == 1'b1, "R2 inc strobe cycle", incStrobe, 1);
    @(posedge clk);
    #1;
    check(incStrobe == 1'b0, "R10 inc single cycle", incStrobe, 0);
    holdFor(GAP + 3);
    expectCounts("R2 R1 first low after reset", i0, d0, p0, 1, 0, 0);
  endtask

  task automatic testDec();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    excursion(1'b0, 1'b1, 1'b0, 20);
    expectCounts("R3 high pulse", i0, d0, p0, 0, 1, 0);
  endtask

  task automatic testShort();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    excursion(1'b1, 1'b0, 1'b0, 4);
    excursion(1'b0, 1'b1, 1'b0, 4);
    setFlags(1'b1, 1'b0, 1'b0);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(GAP + 3);
    expectCounts("R4 short pulses", i0, d0, p0, 0, 0, 0);
  endtask

  task automatic testGap();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b1, 1'b0, 1'b0);
    holdFor(20);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(1);
    excursion(1'b1, 1'b0, 1'b0, 20);
    expectCounts("R5 gap too short", i0, d0, p0, 1, 0, 0);
  endtask

  task automatic testProgLong();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    excursion(1'b0, 1'b1, 1'b1, 35);
    expectCounts("R6 R7 long program hold", i0, d0, p0, 0, 0, 1);
  endtask

  task automatic testProgBrief();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b0, 1'b1, 1'b0);
    holdFor(15);
    setFlags(1'b0, 1'b1, 1'b1);
    holdFor(4);
    setFlags(1'b0, 1'b1, 1'b0);
    holdFor(15);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(GAP + 3);
    expectCounts("R7 brief program touch", i0, d0, p0, 0, 0, 0);
  endtask

  task automatic testSwing();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b1, 1'b0, 1'b0);
    holdFor(15);
    setFlags(1'b0, 1'b1, 1'b0);
    holdFor(15);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(GAP + 3);
    expectCounts("R8 direct swing", i0, d0, p0, 0, 0, 0);
  endtask

  task automatic testFloat();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(50);
    expectCounts("R9 floating pin", i0, d0, p0, 0, 0, 0);
  endtask

  task automatic testPriority();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    excursion(1'b1, 1'b1, 1'b0, 20);
    expectCounts("R11 low and high together", i0, d0, p0, 0, 1, 0);
  endtask

  task automatic testLongHold();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    excursion(1'b1, 1'b0, 1'b0, 100);
    expectCounts("R12 long hold saturates", i0, d0, p0, 1, 0, 0);
  endtask

  task automatic testResetMid();
    int i0 = nInc, d0 = nDec, p0 = nProg;
    setFlags(1'b1, 1'b0, 1'b0);
    holdFor(20);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    holdFor(3);
    setFlags(1'b0, 1'b0, 1'b0);
    holdFor(GAP + 3);
    expectCounts("R1 reset abandons excursion", i0, d0, p0, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testIncLatency();
    testDec();
    testShort();
    testGap();
    testProgLong();
    testProgBrief();
    testSwing();
    testFloat();
    testPriority();
    testLongHold();
    testResetMid();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule